// File: doc/BRIEF.md
# Board Connectivity Test Tree Controller

This block lets board-level test equipment check the solder joints of a group of digital input pins without the chip's normal logic taking part. The pins feed an ordered chain of NAND stages. The chain's result is driven out on a pin that is normally the lowest address input. When every chained pin is held at 1, the shared pin reads high. Pulling any one chained pin low makes the shared pin fall, so a tester can walk a single low level along the pins and see each one respond.

Test mode can only be armed early in life. If the test-enable pin is high while the configuration register has never been written, the block latches test mode. The first configuration write sets a lockout flag. Only power-on reset clears that flag. The register reset does not clear it, so test mode cannot be entered again in normal operation. The critical-alarm pin, the test-enable pin and the supply pins are not connected to the chain.

Top module: `nandtree_ctrl`

## Requirements
- R1: After power-on reset (`rst` high at a clock edge), `test_active`, `cfg_locked` and `pad_oe` are all 0.
- R2: If `test_en` is 1 at a clock edge while `cfg_locked` is 0, `cfg_wr` is 0 and `reg_rst` is 0, then `test_active` is 1 after that edge.
- R3: A clock edge with `cfg_wr` at 1 sets `cfg_locked` to 1. If `test_en` is 1 at that same edge, test mode is not entered.
- R4: While `cfg_locked` is 1, `test_en` has no effect. If `test_active` is 0, it stays 0.
- R5: Only power-on reset clears `cfg_locked`. `reg_rst` leaves it unchanged.
- R6: `reg_rst` clears `test_active` at the next edge and takes priority over entry. If the block is not locked, test mode can be armed again afterwards.
- R7: Once `test_active` is 1, it stays 1 through configuration writes and through `test_en` returning to 0, until `reg_rst` or `rst`.
- R8: In test mode, with every bit of `chain_in` at 1, `pad_dout` is 1.
- R9: In test mode, `pad_dout` is 0 whenever any bit of `chain_in` is 0, including a single low bit at any position. Bit 0 is the first stage (the address-1 pin) and bit CHAIN_W-1 is the last stage (the serial data pin).
- R10: In test mode, `pad_oe` is 1 and `addr0_core` is 0, whatever the value of `pad_din`.
- R11: Outside test mode, `pad_oe` is 0, `pad_dout` is 0, `addr0_core` equals `pad_din`, and `chain_in` has no effect.
- R12: `pad_dout` follows a change of `chain_in` with no clock edge in between; the chain is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| reg_rst | input | 1 | Register reset, synchronous, active high; clears test mode but not the lockout |
| cfg_wr | input | 1 | Configuration register write strobe |
| test_en | input | 1 | Test-enable pin level |
| chain_in | input | CHAIN_W | Chained input pins; bit 0 is the first stage |
| pad_din | input | 1 | Value read from the shared address-0 pad |
| pad_oe | output | 1 | Output enable for the shared pad |
| pad_dout | output | 1 | Value driven on the shared pad (the tree result in test mode) |
| addr0_core | output | 1 | Address bit 0 passed to the core |
| test_active | output | 1 | Test mode is latched |
| cfg_locked | output | 1 | The configuration has been written since power-on |

## Verification
The assertions assume that `rst` is held for at least one clock edge before anything else is checked, and that all control inputs are stable around each rising edge. They do not depend on how many chain bits are low at once, so they hold for any pattern on `chain_in`. The stimulus changes inputs one time unit after each rising edge and samples the outputs before the next edge. It covers the rule on same-edge write and enable, the priority of the register reset, and re-arming after a power-on reset. Every single-low position of the chain is applied from a vector table.

// File: rtl/nandtree_pkg.sv
package nandtree_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_TREE   = 1'b1
  } tmode_e;

  localparam int unsigned DEF_CHAIN_W = 8;

endpackage

// File: rtl/nandtree_chain.sv
module nandtree_chain #(
  parameter int unsigned CHAIN_W = 8
) (
  input  logic [CHAIN_W-1:0] pins,
  output logic               tree_out
);

  localparam int unsigned NODES = CHAIN_W + 1;

  logic [NODES-1:0]   carry;
  logic [CHAIN_W-1:0] nand_n;

  assign carry[0] = 1'b1;

  // each stage is a NAND cell followed by an inverter, so a low on any
  // single pin propagates to the end of the chain
  for (genvar k = 0; k < CHAIN_W; k++) begin : g_stage
    assign nand_n[k]  = ~(carry[k] & pins[k]);
    assign carry[k+1] = ~nand_n[k];
  end

  assign tree_out = carry[NODES-1];

endmodule

// File: rtl/nandtree_arm.sv
module nandtree_arm
  import nandtree_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   reg_rst,
  input  logic   cfg_wr,
  input  logic   test_en,
  output tmode_e mode,
  output logic   locked
);

  tmode_e mode_q;
  logic   locked_q;
  logic   arm_ok;

  // entry needs a level seen strictly before the first write
  assign arm_ok = test_en & ~locked_q & ~cfg_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (cfg_wr) begin
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reg_rst) begin
      mode_q <= MODE_NORMAL;
    end else if (arm_ok) begin
      mode_q <= MODE_TREE;
    end
  end

  assign mode   = mode_q;
  assign locked = locked_q;

endmodule

// File: rtl/nandtree_padmux.sv
module nandtree_padmux
  import nandtree_pkg::*;
(
  input  tmode_e mode,
  input  logic   tree_out,
  input  logic   pad_din,
  output logic   pad_oe,
  output logic   pad_dout,
  output logic   addr0_core
);

  always_comb begin
    unique case (mode)
      MODE_TREE: begin
        pad_oe     = 1'b1;
        pad_dout   = tree_out;
        addr0_core = 1'b0;
      end
      default: begin
        pad_oe     = 1'b0;
        pad_dout   = 1'b0;
        addr0_core = pad_din;
      end
    endcase
  end

endmodule

// File: rtl/nandtree_ctrl.sv
module nandtree_ctrl
  import nandtree_pkg::*;
#(
  parameter int unsigned CHAIN_W = DEF_CHAIN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_rst,
  input  logic               cfg_wr,
  input  logic               test_en,
  input  logic [CHAIN_W-1:0] chain_in,
  input  logic               pad_din,
  output logic               pad_oe,
  output logic               pad_dout,
  output logic               addr0_core,
  output logic               test_active,
  output logic               cfg_locked
);

  tmode_e mode;
  logic   tree_out;

  nandtree_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .reg_rst (reg_rst),
    .cfg_wr  (cfg_wr),
    .test_en (test_en),
    .mode    (mode),
    .locked  (cfg_locked)
  );

  nandtree_chain #(
    .CHAIN_W (CHAIN_W)
  ) u_chain (
    .pins     (chain_in),
    .tree_out (tree_out)
  );

  nandtree_padmux u_mux (
    .mode       (mode),
    .tree_out   (tree_out),
    .pad_din    (pad_din),
    .pad_oe     (pad_oe),
    .pad_dout   (pad_dout),
    .addr0_core (addr0_core)
  );

  assign test_active = (mode == MODE_TREE);

endmodule

// File: rtl/nandtree_ctrl_chk.sv
module nandtree_ctrl_chk #(
  parameter int unsigned CHAIN_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rst,
  input logic               cfg_wr,
  input logic               test_en,
  input logic [CHAIN_W-1:0] chain_in,
  input logic               pad_din,
  input logic               pad_oe,
  input logic               pad_dout,
  input logic               addr0_core,
  input logic               test_active,
  input logic               cfg_locked
);

  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!test_active && !cfg_locked && !pad_oe)); // R1

  AST_ARM_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (test_en && !cfg_locked && !cfg_wr && !reg_rst) |=> test_active); // R2

  AST_WRITE_LOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_locked); // R3

  AST_NO_LATE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cfg_locked && !test_active) |=> !test_active); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> cfg_locked); // R5

  AST_REGRST_EXIT: assert property (@(posedge clk) disable iff (rst)
    reg_rst |=> !test_active); // R6

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (test_active && !reg_rst) |=> test_active); // R7

  AST_TREE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (test_active && (&chain_in)) |-> pad_dout); // R8

  AST_TREE_LOW: assert property (@(posedge clk) disable iff (rst)
    (test_active && !(&chain_in)) |-> !pad_dout); // R9

  AST_TEST_PAD: assert property (@(posedge clk) disable iff (rst)
    test_active |-> (pad_oe && !addr0_core)); // R10

  AST_NORMAL_PAD: assert property (@(posedge clk) disable iff (rst)
    !test_active |-> (!pad_oe && !pad_dout && (addr0_core == pad_din))); // R11

endmodule

bind nandtree_ctrl nandtree_ctrl_chk #(.CHAIN_W(CHAIN_W)) u_chk (.*);

// File: tb/nandtree_ctrl_tb.sv
module nandtree_ctrl_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_rst = 1'b0;
  logic         cfg_wr = 1'b0;
  logic         test_en = 1'b0;
  logic [W-1:0] chain_in = '1;
  logic         pad_din = 1'b0;
  logic         pad_oe, pad_dout, addr0_core, test_active, cfg_locked;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nandtree_ctrl #(.CHAIN_W(W)) u_dut (
    .clk(clk), .rst(rst), .reg_rst(reg_rst), .cfg_wr(cfg_wr),
    .test_en(test_en), .chain_in(chain_in), .pad_din(pad_din),
    .pad_oe(pad_oe), .pad_dout(pad_dout), .addr0_core(addr0_core),
    .test_active(test_active), .cfg_locked(cfg_locked)
  );

  // {chain_in, pad_din, expected pad_dout, expected addr0_core} in test mode
  localparam logic [10:0] VEC [13] = '{
    {8'hFF, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b0},
    {8'hFE, 1'b1, 1'b0, 1'b0},
    {8'hFD, 1'b0, 1'b0, 1'b0},
    {8'hFB, 1'b1, 1'b0, 1'b0},
    {8'hF7, 1'b0, 1'b0, 1'b0},
    {8'hEF, 1'b1, 1'b0, 1'b0},
    {8'hDF, 1'b0, 1'b0, 1'b0},
    {8'hBF, 1'b1, 1'b0, 1'b0},
    {8'h7F, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0},
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    check("R1 test_active", test_active, 0);
    check("R1 cfg_locked", cfg_locked, 0);
    check("R1 pad_oe", pad_oe, 0);

    // normal mode: pad passes through, chain ignored
    chain_in = '1; pad_din = 1'b1; #1;
    check("R11 addr0_core", addr0_core, 1);
    check("R11 pad_dout", pad_dout, 0);
    chain_in = 8'h00; pad_din = 1'b0; #1;
    check("R11 addr0_core low", addr0_core, 0);
    check("R11 pad_oe", pad_oe, 0);

    // arm test mode
    test_en = 1'b1; tick();
    check("R2 entry", test_active, 1);
    test_en = 1'b0; tick();
    check("R7 hold after enable drops", test_active, 1);

    for (int i = 0; i < 13; i++) begin
      chain_in = VEC[i][10:3];
      pad_din  = VEC[i][2];
      #1;
      check($sformatf("R8/R9 vec%0d pad_dout", i), pad_dout, VEC[i][1]);
      check($sformatf("R10 vec%0d addr0_core", i), addr0_core, VEC[i][0]);
      check($sformatf("R10 vec%0d pad_oe", i), pad_oe, 1);
    end

    // R12: chain responds with no clock edge
    @(negedge clk);
    chain_in = '1; #0.5;
    check("R12 comb high", pad_dout, 1);
    chain_in[W-1] = 1'b0; #0.5;
    check("R12 comb low last stage", pad_dout, 0);
    chain_in = '1;
    tick();

    // first write locks but keeps active mode
    cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    check("R3 lock set", cfg_locked, 1);
    check("R7 hold through write", test_active, 1);

    reg_rst = 1'b1; tick(); reg_rst = 1'b0;
    check("R6 exit on reg_rst", test_active, 0);
    check("R5 lock kept by reg_rst", cfg_locked, 1);

    test_en = 1'b1; chain_in = '1; pad_din = 1'b1; tick(); tick();
    check("R4 no reentry", test_active, 0);
    check("R11 pad_dout ignored", pad_dout, 0);
    check("R11 addr0 passthrough", addr0_core, 1);
    test_en = 1'b0;

    rst = 1'b1; tick(); rst = 1'b0;
    check("R5 lock cleared by rst", cfg_locked, 0);

    // same-edge write and enable
    test_en = 1'b1; cfg_wr = 1'b1; tick();
    test_en = 1'b0; cfg_wr = 1'b0;
    check("R3 same-edge no entry", test_active, 0);
    check("R3 same-edge lock", cfg_locked, 1);

    rst = 1'b1; tick(); rst = 1'b0;
    test_en = 1'b1; reg_rst = 1'b1; tick();
    check("R6 reg_rst beats entry", test_active, 0);
    reg_rst = 1'b0; tick();
    check("R6 rearm when unlocked", test_active, 1);
    check("R5 still unlocked", cfg_locked, 0);
    test_en = 1'b0; tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule